// File: doc/BRIEF.md
# Scrolled Tile Plane Pixel Fetcher

This block produces the colour of one scrolled background plane at one screen pixel. A request carries a screen coordinate and a plane select. The block looks up that plane's horizontal and vertical scroll offsets and applies them to the coordinate. It wraps the result to the configured plane size and fetches the 16-bit name-table entry of the tile under the point. It then fetches the 4-bit pixel from the tile's pattern data, applying the entry's flips.

The answer is a 6-bit colour index, formed as palette select followed by pixel value, together with the tile's priority bit and a transparent flag. A compositor outside the block combines these with the other layers.

The work is split into three pipeline stages. Each stage reads through its own synchronous read port, and every port returns data one clock after it is given an address. The three stages are the scroll fetch, the name-table fetch and the pattern fetch. One request can be accepted on every clock. The scroll modes, the plane size and the base addresses of the tables come from static configuration inputs.

Top module: `tile_plane_fetch`

## Requirements
- R1: After reset, `out_valid` is 0. A request sampled at clock edge k shows its result on the outputs, with `out_valid` high, after edge k+2. Cycles with no request give `out_valid` 0.
- R2: A name entry holds its fields at these bit positions: bit 15 is priority, bits 14:13 are the palette, bit 12 is the vertical flip, bit 11 is the horizontal flip, and bits 10:0 are the tile index. `out_color` is {palette, pixel} and `out_pri` is bit 15.
- R3: `out_transp` is 1 exactly when the fetched pixel value is 0, whatever the palette.
- R4: The plane x is (screen x − hoffset) mod W, where hoffset is bits 9:0 of the horizontal scroll entry. W is 256, 512 or 1024 pixels for `cfg_wsel` 0, 1 or 2; a value of 3 also means 1024.
- R5: The plane y is (screen y + voffset) mod H, where voffset is bits 9:0 of the vertical scroll entry. H is selected by `cfg_hsel` with the same encoding as `cfg_wsel`.
- R6: The horizontal scroll word address is `cfg_hs_base` + 2·L + plane. L is 0 when `cfg_hmode` is 0 (full screen). L is y with its low 3 bits cleared when `cfg_hmode` is 1 (8-line rows). L is y when `cfg_hmode` is 2 or 3 (per line).
- R7: The vertical scroll word address is 2·C + plane. C is screen x / 16 when `cfg_vcol` is 1 (16-pixel columns) and 0 when `cfg_vcol` is 0.
- R8: The name-table word address is `cfg_nt_base` + (plane y / 8)·(W / 8) + plane x / 8, stored row by row and wrapping modulo the memory size.
- R9: The pattern word address is tile·16 + row·2 + col/4. Within a word, pixel col mod 4 = 0 is bits 15:12, and later pixels take successively lower nibbles.
- R10: Horizontal flip maps fine column c to 7−c. Vertical flip maps fine row r to 7−r.
- R11: Requests may arrive on consecutive clocks with any pattern of gaps. Every result comes out in order, with no loss and no duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_x | input | XW | Screen x |
| req_y | input | YW | Screen y |
| req_plane | input | 1 | Plane select (0 or 1) |
| cfg_hmode | input | 2 | Horizontal scroll granularity |
| cfg_vcol | input | 1 | Per-column vertical scroll enable |
| cfg_wsel | input | 2 | Plane width code |
| cfg_hsel | input | 2 | Plane height code |
| cfg_nt_base | input | AW | Name-table word base |
| cfg_hs_base | input | AW | Horizontal scroll table word base |
| hs_addr | output | AW | Horizontal scroll read address |
| hs_data | input | 16 | Horizontal scroll read data (one clock later) |
| vs_addr | output | VAW | Vertical scroll read address |
| vs_data | input | 16 | Vertical scroll read data |
| nt_addr | output | AW | Name-table read address |
| nt_data | input | 16 | Name-table read data |
| pat_addr | output | AW | Pattern read address |
| pat_data | input | 16 | Pattern read data |
| out_valid | output | 1 | Result valid |
| out_color | output | 6 | {palette, pixel} |
| out_pri | output | 1 | Tile priority |
| out_transp | output | 1 | Pixel value is zero |

## Verification
The bench drives offsets at the edges of the wrap, such as 1, 1019 and 1023, across all three plane widths and heights. A design that subtracts on the wrong axis, or masks before the subtraction, shows a plane shifted the wrong way or torn at the seam. Row mode is exercised on lines that are not multiples of eight. A design that fails to clear the low line bits scrolls each line separately. Column mode sweeps the full screen width, so an off-by-one column reads a neighbouring offset. The scans use random name entries with both flips set and with zero pixels, and random gaps between back-to-back requests. These catch swapped nibble order, flips applied to the wrong axis, a palette taken from the wrong cycle, and results that drift against their requests.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

    typedef enum logic [1:0] {
        HS_FULL  = 2'd0,
        HS_ROW   = 2'd1,
        HS_LINE  = 2'd2,
        HS_LINE2 = 2'd3
    } hs_mode_e;

    // 16-bit name entry, fields from bit 15 down to bit 0
    typedef struct packed {
        logic        pri;
        logic [1:0]  pal;
        logic        vflip;
        logic        hflip;
        logic [10:0] tile;
    } name_ent_t;

    localparam int TILE_W = 11;

    // plane size code: 0 -> smallest, 1 -> double, 2/3 -> quadruple
    function automatic logic [1:0] size_step(input logic [1:0] sel);
        return (sel == 2'd3) ? 2'd2 : sel;
    endfunction

endpackage

// File: rtl/tpf_scroll_stage.sv
module tpf_scroll_stage
    import tpf_pkg::*;
#(
    parameter int XW  = 9,
    parameter int YW  = 8,
    parameter int AW  = 15,
    parameter int VAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [XW-1:0]  req_x,
    input  logic [YW-1:0]  req_y,
    input  logic           req_plane,
    input  logic [1:0]     cfg_hmode,
    input  logic           cfg_vcol,
    input  logic [AW-1:0]  cfg_hs_base,
    output logic [AW-1:0]  hs_addr,
    output logic [VAW-1:0] vs_addr,
    output logic           s1_valid,
    output logic [XW-1:0]  s1_x,
    output logic [YW-1:0]  s1_y
);
    localparam int CW = XW - 4;

    typedef struct packed {
        logic          valid;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } s1_t;

    s1_t s1_d, s1_q;
    logic [YW-1:0] line_sel;
    logic [CW-1:0] col_sel;

    always_comb begin
        case (hs_mode_e'(cfg_hmode))
            HS_FULL: line_sel = '0;
            HS_ROW:  line_sel = {req_y[YW-1:3], 3'b000};
            default: line_sel = req_y;
        endcase
        col_sel    = cfg_vcol ? req_x[XW-1:4] : '0;
        hs_addr    = cfg_hs_base + AW'({line_sel, req_plane});
        vs_addr    = VAW'({col_sel, req_plane});
        s1_d.valid = req_valid;
        s1_d.x     = req_x;
        s1_d.y     = req_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign s1_valid = s1_q.valid;
    assign s1_x     = s1_q.x;
    assign s1_y     = s1_q.y;

    assert_valid_chain_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> s1_valid);

    assert_full_hs_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_hmode == 2'd0) |-> ((hs_addr - cfg_hs_base) <= AW'(1)));

endmodule

// File: rtl/tpf_map_stage.sv
module tpf_map_stage
    import tpf_pkg::*;
#(
    parameter int XW = 9,
    parameter int YW = 8,
    parameter int AW = 15,
    parameter int OW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [XW-1:0] in_x,
    input  logic [YW-1:0] in_y,
    input  logic [15:0]   hs_data,
    input  logic [15:0]   vs_data,
    input  logic [1:0]    cfg_wsel,
    input  logic [1:0]    cfg_hsel,
    input  logic [AW-1:0] cfg_nt_base,
    output logic [AW-1:0] nt_addr,
    output logic          s2_valid,
    output logic [2:0]    s2_fx,
    output logic [2:0]    s2_fy
);
    localparam int TW    = OW - 3;   // tile coordinate width
    localparam int SHMIN = OW - 5;   // log2 of tiles per row at smallest width

    typedef struct packed {
        logic       valid;
        logic [2:0] fx;
        logic [2:0] fy;
    } s2_t;

    s2_t s2_d, s2_q;
    logic [OW-1:0] px, py, wmask, hmask;
    logic [TW-1:0] tx, ty;
    logic [AW-1:0] row_off;

    function automatic logic [OW-1:0] size_mask(input logic [1:0] sel);
        logic [OW:0] one;
        one = (OW+1)'(1) << (OW - 2 + int'(size_step(sel)));
        return OW'(one - 1'b1);
    endfunction

    always_comb begin
        wmask   = size_mask(cfg_wsel);
        hmask   = size_mask(cfg_hsel);
        px      = (OW'(in_x) - hs_data[OW-1:0]) & wmask;
        py      = (OW'(in_y) + vs_data[OW-1:0]) & hmask;
        tx      = px[OW-1:3];
        ty      = py[OW-1:3];
        row_off = AW'(ty) << (SHMIN + int'(size_step(cfg_wsel)));
        nt_addr = cfg_nt_base + row_off + AW'(tx);
        s2_d.valid = in_valid;
        s2_d.fx    = px[2:0];
        s2_d.fy    = py[2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

    assign s2_valid = s2_q.valid;
    assign s2_fx    = s2_q.fx;
    assign s2_fy    = s2_q.fy;

    assert_valid_chain_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s2_valid);

    assert_nt_in_plane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ((nt_addr - cfg_nt_base) <
            (AW'(1) << (2 * SHMIN + int'(size_step(cfg_wsel)) + int'(size_step(cfg_hsel))))));

endmodule

// File: rtl/tpf_pat_stage.sv
module tpf_pat_stage
    import tpf_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_fx,
    input  logic [2:0]    in_fy,
    input  logic [15:0]   nt_data,
    input  logic [15:0]   pat_data,
    output logic [AW-1:0] pat_addr,
    output logic          out_valid,
    output logic [5:0]    out_color,
    output logic          out_pri,
    output logic          out_transp
);
    typedef struct packed {
        logic       valid;
        logic       pri;
        logic [1:0] pal;
        logic [1:0] nsel;
    } s3_t;

    s3_t s3_d, s3_q;
    name_ent_t ent;
    logic [2:0] row, col;
    logic [3:0] nib;

    always_comb begin
        ent      = name_ent_t'(nt_data);
        row      = ent.vflip ? ~in_fy : in_fy;
        col      = ent.hflip ? ~in_fx : in_fx;
        pat_addr = AW'({ent.tile, row, col[2]});
        s3_d.valid = in_valid;
        s3_d.pri   = ent.pri;
        s3_d.pal   = ent.pal;
        s3_d.nsel  = col[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s3_d;
    end

    always_comb begin
        case (s3_q.nsel)
            2'd0:    nib = pat_data[15:12];
            2'd1:    nib = pat_data[11:8];
            2'd2:    nib = pat_data[7:4];
            default: nib = pat_data[3:0];
        endcase
        out_valid  = s3_q.valid;
        out_pri    = s3_q.pri;
        out_color  = {s3_q.pal, nib};
        out_transp = (nib == 4'd0);
    end

    assert_valid_chain_c_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_palette_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_color[5:4] == $past(nt_data[14:13]) && out_pri == $past(nt_data[15])));

endmodule

// File: rtl/tile_plane_fetch.sv
module tile_plane_fetch
    import tpf_pkg::*;
#(
    parameter int XW  = 9,
    parameter int YW  = 8,
    parameter int AW  = 15,
    parameter int VAW = 6,
    parameter int OW  = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [XW-1:0]  req_x,
    input  logic [YW-1:0]  req_y,
    input  logic           req_plane,
    input  logic [1:0]     cfg_hmode,
    input  logic           cfg_vcol,
    input  logic [1:0]     cfg_wsel,
    input  logic [1:0]     cfg_hsel,
    input  logic [AW-1:0]  cfg_nt_base,
    input  logic [AW-1:0]  cfg_hs_base,
    output logic [AW-1:0]  hs_addr,
    input  logic [15:0]    hs_data,
    output logic [VAW-1:0] vs_addr,
    input  logic [15:0]    vs_data,
    output logic [AW-1:0]  nt_addr,
    input  logic [15:0]    nt_data,
    output logic [AW-1:0]  pat_addr,
    input  logic [15:0]    pat_data,
    output logic           out_valid,
    output logic [5:0]     out_color,
    output logic           out_pri,
    output logic           out_transp
);
    logic          s1_valid, s2_valid;
    logic [XW-1:0] s1_x;
    logic [YW-1:0] s1_y;
    logic [2:0]    s2_fx, s2_fy;

    tpf_scroll_stage #(.XW(XW), .YW(YW), .AW(AW), .VAW(VAW)) u_scroll (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_x(req_x), .req_y(req_y), .req_plane(req_plane),
        .cfg_hmode(cfg_hmode), .cfg_vcol(cfg_vcol), .cfg_hs_base(cfg_hs_base),
        .hs_addr(hs_addr), .vs_addr(vs_addr),
        .s1_valid(s1_valid), .s1_x(s1_x), .s1_y(s1_y)
    );

    tpf_map_stage #(.XW(XW), .YW(YW), .AW(AW), .OW(OW)) u_map (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s1_valid), .in_x(s1_x), .in_y(s1_y),
        .hs_data(hs_data), .vs_data(vs_data),
        .cfg_wsel(cfg_wsel), .cfg_hsel(cfg_hsel), .cfg_nt_base(cfg_nt_base),
        .nt_addr(nt_addr),
        .s2_valid(s2_valid), .s2_fx(s2_fx), .s2_fy(s2_fy)
    );

    tpf_pat_stage #(.AW(AW)) u_pat (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s2_valid), .in_fx(s2_fx), .in_fy(s2_fy),
        .nt_data(nt_data), .pat_data(pat_data),
        .pat_addr(pat_addr),
        .out_valid(out_valid), .out_color(out_color),
        .out_pri(out_pri), .out_transp(out_transp)
    );

endmodule

// File: tb/tile_plane_fetch_tb.sv
module tile_plane_fetch_tb;
    localparam int XW = 9, YW = 8, AW = 15, VAW = 6;
    localparam int MEMW = 32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic           req_valid = 1'b0;
    logic [XW-1:0]  req_x = '0;
    logic [YW-1:0]  req_y = '0;
    logic           req_plane = 1'b0;
    logic [1:0]     cfg_hmode = '0, cfg_wsel = '0, cfg_hsel = '0;
    logic           cfg_vcol = 1'b0;
    logic [AW-1:0]  cfg_nt_base = 15'h2000, cfg_hs_base = 15'h7000;
    logic [AW-1:0]  hs_addr, nt_addr, pat_addr;
    logic [VAW-1:0] vs_addr;
    logic [15:0]    hs_data, vs_data, nt_data, pat_data;
    logic           out_valid, out_pri, out_transp;
    logic [5:0]     out_color;

    logic [15:0] vram [0:MEMW-1];
    logic [15:0] vsram [0:63];

    always @(posedge clk) begin
        hs_data  <= vram[hs_addr];
        vs_data  <= vsram[vs_addr];
        nt_data  <= vram[nt_addr];
        pat_data <= vram[pat_addr];
    end

    tile_plane_fetch u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_x(req_x), .req_y(req_y),
        .req_plane(req_plane), .cfg_hmode(cfg_hmode), .cfg_vcol(cfg_vcol),
        .cfg_wsel(cfg_wsel), .cfg_hsel(cfg_hsel), .cfg_nt_base(cfg_nt_base),
        .cfg_hs_base(cfg_hs_base), .hs_addr(hs_addr), .hs_data(hs_data),
        .vs_addr(vs_addr), .vs_data(vs_data), .nt_addr(nt_addr), .nt_data(nt_data),
        .pat_addr(pat_addr), .pat_data(pat_data), .out_valid(out_valid),
        .out_color(out_color), .out_pri(out_pri), .out_transp(out_transp)
    );

    int total = 0, bad = 0;
    bit done = 0;
    string tag = "R1";

    bit    q_v[$];
    int    q_w[$];
    string q_t[$];

    function automatic int ref_pix(int x, int y, int p);
        int line, hoff, c, voff, wb, hb, px, py, e, fr, fc, w, nib;
        line = (cfg_hmode == 0) ? 0 : (cfg_hmode == 1) ? (y & ~7) : y;
        hoff = vram[(cfg_hs_base + 2 * line + p) % MEMW] & 1023;
        c    = cfg_vcol ? (x / 16) : 0;
        voff = vsram[2 * c + p] & 1023;
        wb   = 256 << ((cfg_wsel == 3) ? 2 : cfg_wsel);
        hb   = 256 << ((cfg_hsel == 3) ? 2 : cfg_hsel);
        px   = ((x - hoff + 2048) % 1024) % wb;
        py   = ((y + voff) % 1024) % hb;
        e    = vram[(cfg_nt_base + (py / 8) * (wb / 8) + px / 8) % MEMW];
        fr   = py % 8;
        fc   = px % 8;
        if (((e >> 12) & 1) == 1) fr = 7 - fr;
        if (((e >> 11) & 1) == 1) fc = 7 - fc;
        w    = vram[((e & 2047) * 16 + fr * 2 + fc / 4) % MEMW];
        nib  = (w >> (12 - 4 * (fc % 4))) & 15;
        return (((e >> 15) & 1) << 7) | ((nib == 0 ? 1 : 0) << 6) | (((e >> 13) & 3) << 4) | nib;
    endfunction

    task automatic step(input bit v, input int x, input int y, input int p);
        @(negedge clk);
        if (q_v.size() == 3) begin
            bit    ev;
            int    ew;
            string et;
            int    aw;
            ev = q_v.pop_front();
            ew = q_w.pop_front();
            et = q_t.pop_front();
            aw = {24'd0, out_pri, out_transp, out_color};
            total++;
            if (out_valid !== ev) begin
                bad++;
                $display("FAIL %s valid: actual=%0b expected=%0b", et, out_valid, ev);
            end else if (ev && aw != ew) begin
                bad++;
                $display("FAIL %s pixel: actual=%02h expected=%02h", et, aw, ew);
            end
        end
        req_valid = v;
        req_x     = XW'(x);
        req_y     = YW'(y);
        req_plane = p[0];
        q_v.push_back(v);
        q_w.push_back(v ? ref_pix(x, y, p) : 0);
        q_t.push_back(tag);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    endtask

    task automatic set_full(input int hoff, input int voff);
        vram[cfg_hs_base]     = 16'(hoff);
        vram[cfg_hs_base + 1] = 16'(hoff + 77);
        vsram[0] = 16'(voff);
        vsram[1] = 16'(voff + 13);
    endtask

    initial begin
        int seed;
        int offs[5];
        int voffs[4];
        seed = 32'h1357;
        for (int i = 0; i < MEMW; i++) begin
            seed = seed * 1103515245 + 12345;
            vram[i] = 16'(seed >> 8);
        end
        for (int i = 0; i < 64; i++) vsram[i] = 16'(i * 97 + 5);

        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: actual=%0b expected=0", out_valid);
        end
        rst_n = 1'b1;

        // R2 R3 R9 R10: no scroll, decode and pattern addressing over random entries
        tag = "R2 R3 R9 R10";
        set_full(0, 0);
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 64; x++) step(1, x, y, 0);
        drain();

        // R4 R8: horizontal wrap at each width
        tag = "R4 R8";
        offs = '{1, 5, 1019, 1023, 300};
        for (int ws = 0; ws < 4; ws++) begin
            cfg_wsel = 2'(ws);
            foreach (offs[k]) begin
                set_full(offs[k], 0);
                for (int x = 0; x < 320; x += 7) step(1, x, 3, 0);
                drain();
            end
        end

        // R5: vertical wrap at each height
        tag = "R5";
        voffs = '{1, 255, 1023, 700};
        for (int hs = 0; hs < 3; hs++) begin
            cfg_hsel = 2'(hs);
            foreach (voffs[k]) begin
                set_full(40, voffs[k]);
                for (int y = 0; y < 224; y += 5) step(1, 10, y, 1);
                drain();
            end
        end

        // R6: row and line horizontal scroll
        tag = "R6";
        for (int m = 1; m < 4; m++) begin
            cfg_hmode = 2'(m);
            for (int y = 0; y < 224; y++) step(1, 100 + (y % 9), y, y % 2);
            drain();
        end
        cfg_hmode = 2'd0;

        // R7: column vertical scroll
        tag = "R7";
        cfg_vcol = 1'b1;
        for (int x = 0; x < 320; x += 3) step(1, x, 50, x % 2);
        drain();

        // R11: mixed configs, back-to-back with random gaps
        tag = "R11";
        for (int blk = 0; blk < 6; blk++) begin
            cfg_hmode   = 2'($urandom % 4);
            cfg_vcol    = 1'($urandom % 2);
            cfg_wsel    = 2'($urandom % 4);
            cfg_hsel    = 2'($urandom % 4);
            cfg_nt_base = AW'($urandom);
            for (int i = 0; i < 300; i++)
                step(($urandom % 4) != 0, $urandom % 320, $urandom % 224, $urandom % 2);
            drain();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule